// File: doc/BRIEF.md
# Interrupt Machine-State Controller

This block keeps the interrupt-related machine-state bits of a small processor core: the external interrupt enable (EE), the machine-check enable (ME) and the recoverable-state flag (RI). It also keeps the two save/restore registers that hold the return address and the saved copy of those three bits. The core's pipeline drives one-cycle strobes into it: exception entry, return from interrupt, a direct write of the machine state, and special-register writes and reads. The block answers with the current bit values and a software-emulation trap request.

Three special-register numbers act as quick EE/RI toggles for handler prologues, handler epilogues and critical code sections. Writing one of them loads a fixed EE/RI pair and carries no data. Reading one of them is an unimplemented operation and raises the emulation trap. On every exception entry, RI is shadowed into the saved state and then cleared. A return from interrupt brings it back.

Top module: `intr_state_ctl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `ee`, `me`, `ri`, `srr0` and `srr1` are all 0.
- R2: On a cycle with `exc_take` high, at the next clock edge `srr0` takes `exc_pc` and `srr1` takes the pre-entry state packed as bit 2 = EE, bit 1 = ME, bit 0 = RI.
- R3: Every exception entry clears RI at the same edge.
- R4: Entry with `exc_kind` 0 (system reset) or 1 (machine check) clears ME. Any other kind leaves ME unchanged.
- R5: Entry with `exc_kind` 2 (external), 3 (decrementer), 4 (debug-port unmaskable) or 5 (breakpoint, nonmaskable mode) clears EE. Kinds 0, 1, 6 and 7 leave EE unchanged.
- R6: A `rfi` strobe loads EE, ME and RI from `srr1` bits 2, 1 and 0.
- R7: A `msr_wr` strobe loads EE, ME and RI from `msr_wdata` bits 2, 1 and 0.
- R8: `spr_wr` with `spr_num` 80 sets EE=1 and RI=1. With 81 it sets EE=0 and RI=1. With 82 it sets EE=0 and RI=0. ME is unchanged in all three cases, and a write to any other number changes nothing.
- R9: `emu_trap` is high in the same cycle as `spr_rd` with `spr_num` 80, 81 or 82, and low otherwise.
- R10: When strobes coincide, `exc_take` wins over `rfi`, `rfi` wins over `msr_wr`, and `msr_wr` wins over `spr_wr`. The losing strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception entry strobe |
| exc_kind | input | 3 | Exception type code |
| exc_pc | input | 32 | Return address saved on entry |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_wr | input | 1 | Direct machine-state write strobe |
| msr_wdata | input | 3 | New {EE, ME, RI} |
| spr_wr | input | 1 | Special-register write strobe |
| spr_rd | input | 1 | Special-register read strobe |
| spr_num | input | 10 | Special-register number |
| ee | output | 1 | External interrupt enable |
| me | output | 1 | Machine-check enable |
| ri | output | 1 | Recoverable-state flag |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 3 | Saved {EE, ME, RI} |
| emu_trap | output | 1 | Emulation trap request |

## Verification
Every state result (`ee`, `me`, `ri`, `srr0`, `srr1`) passes through one register. It is due one edge after the strobe that causes it. The bench drives on the falling edge and compares on the following falling edge, after its model has stepped once. `emu_trap` is combinational, so it is checked in the same cycle as the read strobe, shortly after the inputs settle. The strobes are cleared right after the active edge, so each stimulus counts exactly once.

// File: rtl/intr_state_ctl.sv
module intr_state_ctl #(
  parameter int PC_W       = 32,
  parameter int SPRN_W     = 10,
  parameter int KIND_W     = 3,
  parameter int SPR_EN_ALL = 80,
  parameter int SPR_EN_RI  = 81,
  parameter int SPR_NO_RI  = 82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [KIND_W-1:0] exc_kind,
  input  logic [PC_W-1:0]   exc_pc,
  input  logic              rfi,
  input  logic              msr_wr,
  input  logic [2:0]        msr_wdata,
  input  logic              spr_wr,
  input  logic              spr_rd,
  input  logic [SPRN_W-1:0] spr_num,
  output logic              ee,
  output logic              me,
  output logic              ri,
  output logic [PC_W-1:0]   srr0,
  output logic [2:0]        srr1,
  output logic              emu_trap
);
  localparam int B_EE = 2;
  localparam int B_ME = 1;
  localparam int B_RI = 0;

  logic [2:0] msr;
  logic hit_all, hit_ri, hit_none, kill_me, kill_ee;

  assign hit_all  = spr_num == SPRN_W'(SPR_EN_ALL);
  assign hit_ri   = spr_num == SPRN_W'(SPR_EN_RI);
  assign hit_none = spr_num == SPRN_W'(SPR_NO_RI);
  assign kill_me  = exc_kind < KIND_W'(2);
  assign kill_ee  = (exc_kind >= KIND_W'(2)) && (exc_kind <= KIND_W'(5));

  assign ee = msr[B_EE];
  assign me = msr[B_ME];
  assign ri = msr[B_RI];
  assign emu_trap = spr_rd && (hit_all || hit_ri || hit_none);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr  <= '0;
      srr0 <= '0;
      srr1 <= '0;
    end else if (exc_take) begin
      srr0 <= exc_pc;
      srr1 <= msr;
      msr  <= {msr[B_EE] & ~kill_ee, msr[B_ME] & ~kill_me, 1'b0};
    end else if (rfi) begin
      msr <= srr1;
    end else if (msr_wr) begin
      msr <= msr_wdata;
    end else if (spr_wr) begin
      if (hit_all)       msr <= {1'b1, msr[B_ME], 1'b1};
      else if (hit_ri)   msr <= {1'b0, msr[B_ME], 1'b1};
      else if (hit_none) msr <= {1'b0, msr[B_ME], 1'b0};
    end
  end

  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> srr0 == $past(exc_pc) && srr1 == $past({ee, me, ri})); // R2
  AST_ENTRY_RI: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !ri); // R3
  AST_ENTRY_ME: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_kind < KIND_W'(2) |=> !me); // R4
  AST_RFI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take && rfi |=> {ee, me, ri} == $past(srr1)); // R6
  AST_SPR_ME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    spr_wr && !exc_take && !rfi && !msr_wr |=> $stable(me)); // R8
  AST_TRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    emu_trap |-> spr_rd); // R9
  AST_SRR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(srr0) && $stable(srr1)); // R10
endmodule

// File: tb/sim_intr_state_ctl.sv
module sim_intr_state_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic exc_take = 0, rfi = 0, msr_wr = 0, spr_wr = 0, spr_rd = 0;
  logic [2:0] exc_kind = 0, msr_wdata = 0;
  logic [31:0] exc_pc = 0;
  logic [9:0] spr_num = 0;
  logic ee, me, ri, emu_trap;
  logic [31:0] srr0;
  logic [2:0] srr1;

  logic [2:0] m_msr = 0, m_srr1 = 0;
  logic [31:0] m_srr0 = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  intr_state_ctl u0 (.clk, .rst_n, .exc_take, .exc_kind, .exc_pc, .rfi, .msr_wr,
    .msr_wdata, .spr_wr, .spr_rd, .spr_num, .ee, .me, .ri, .srr0, .srr1, .emu_trap);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] next_msr(logic [2:0] cur, logic [2:0] s1);
    logic [2:0] n = cur;
    if (exc_take) begin
      n[0] = 0;
      if (exc_kind <= 1) n[1] = 0;
      if (exc_kind >= 2 && exc_kind <= 5) n[2] = 0;
    end else if (rfi) n = s1;
    else if (msr_wr) n = msr_wdata;
    else if (spr_wr) begin
      if (spr_num == 80) n = {1'b1, cur[1], 1'b1};
      else if (spr_num == 81) n = {1'b0, cur[1], 1'b1};
      else if (spr_num == 82) n = {1'b0, cur[1], 1'b0};
    end
    return n;
  endfunction

  function automatic logic exp_trap();
    return spr_rd && (spr_num == 80 || spr_num == 81 || spr_num == 82);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    exc_take = 0; rfi = 0; msr_wr = 0; spr_wr = 0; spr_rd = 0;
  endtask

  task automatic step(string req);
    logic [2:0] nm;
    #1;
    check({req, " trap"}, 64'(emu_trap), 64'(exp_trap()));
    nm = next_msr(m_msr, m_srr1);
    if (exc_take) begin m_srr0 = exc_pc; m_srr1 = m_msr; end
    m_msr = nm;
    @(posedge clk); #1;
    clear_in();
    @(negedge clk);
    check(req, {26'd0, ee, me, ri, srr1, srr0}, {26'd0, m_msr, m_srr1, m_srr0});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 in reset", {ee, me, ri, srr1, srr0}, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {ee, me, ri, srr1, srr0, emu_trap}, '0);

    msr_wr = 1; msr_wdata = 3'b111; step("R7 write all");
    exc_take = 1; exc_kind = 2; exc_pc = 32'hDEAD_BEE0; step("R2 R3 R5 external entry");
    check("R5 ee cleared", 64'(ee), 0);
    check("R2 srr1 saved", 64'(srr1), 64'd7);
    rfi = 1; step("R6 return");
    check("R6 ri restored", 64'(ri), 1);
    exc_take = 1; exc_kind = 0; exc_pc = 32'h100; step("R4 reset-kind entry");
    check("R4 me cleared", 64'(me), 0);
    msr_wr = 1; msr_wdata = 3'b111; step("R7 restore");
    exc_take = 1; exc_kind = 6; exc_pc = 32'h700; step("R5 other kind keeps ee");
    check("R5 ee kept", 64'(ee), 1);
    spr_wr = 1; spr_num = 82; step("R8 spr 82");
    spr_wr = 1; spr_num = 81; step("R8 spr 81");
    spr_wr = 1; spr_num = 80; step("R8 spr 80");
    spr_wr = 1; spr_num = 82; step("R8 spr 82 again");
    spr_wr = 1; spr_num = 83; step("R8 spr 83 ignored");
    check("R8 ignored state", 64'({ee, ri}), 0);
    spr_rd = 1; spr_num = 80; step("R9 read 80");
    spr_rd = 1; spr_num = 82; step("R9 read 82");
    spr_rd = 1; spr_num = 79; step("R9 read 79");
    exc_take = 1; exc_kind = 3; exc_pc = 32'h55; msr_wr = 1; msr_wdata = 3'b111;
    spr_wr = 1; spr_num = 80; step("R10 entry beats writes");
    rfi = 1; msr_wr = 1; msr_wdata = 3'b010; step("R10 rfi beats msr write");
    msr_wr = 1; msr_wdata = 3'b000; spr_wr = 1; spr_num = 80; step("R10 msr beats spr");

    for (int i = 0; i < 3000; i++) begin
      exc_take = ($urandom % 8) == 0;
      exc_kind = 3'($urandom);
      exc_pc = $urandom;
      rfi = ($urandom % 8) == 0;
      msr_wr = ($urandom % 8) == 0;
      msr_wdata = 3'($urandom);
      spr_wr = ($urandom % 4) == 0;
      spr_rd = ($urandom % 4) == 0;
      spr_num = ($urandom % 2) ? 10'(80 + $urandom % 3) : 10'($urandom);
      step("R10 random mix");
    end
    summary();
  end
endmodule